// File: doc/BRIEF.md
# Split Wide Multiply-Add Unit

This integer execution unit forms a double-width multiply-accumulate, `A*B + {addend_high, addend_low}`, as two separate single-width operations. Both multiplicands are unsigned, and the full product is twice the operand width. A one-bit carry flag persists between the two operations. The first operation returns the low word of the product plus the low addend word and records the carry-out in the flag. The second operation returns the high word of the product plus the high addend word plus the stored carry.

Each operation carries three modifier bits:
- `op_hi` selects the upper half of the product.
- `op_ext` adds the stored flag as a carry-in.
- `op_setc` writes the carry-out of the sum into the flag.

Results are registered. An accepted operation appears on `result` one cycle later, together with `out_valid`. The pair of results, low word first, is typically used as one 64-bit byte address.

Top module: `madd_split`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise. `result` keeps its value in cycles with no accepted operation.
- R2: With `op_hi`=0, the result is the low W bits of `A*B` plus `addend`, plus the carry-in, taken modulo 2^W.
- R3: With `op_hi`=1, the result is the upper W bits of the 2W-bit unsigned product `A*B` plus `addend`, plus the carry-in, taken modulo 2^W.
- R4: With `op_ext`=1, the carry-in is the carry flag as it stood before the operation. With `op_ext`=0, the carry-in is 0.
- R5: An accepted operation with `op_setc`=1 writes the carry-out of its W-bit sum into the flag. The new value is visible on `carry_flag` together with the result, and it serves as carry-in to an operation accepted in the very next cycle.
- R6: The flag keeps its value across accepted operations with `op_setc`=0 and across cycles with `in_valid`=0, whatever the modifier inputs are.
- R7: A synchronous reset (`rst`=1) clears `carry_flag` and `out_valid` to 0.
- R8: A low operation with `op_setc` followed by a high operation with `op_ext` gives `{high, low}` = `A*B + {addend_high, addend_low}` modulo 2^(2W). This includes all-ones operands and addends.
- R9: Parameter `MUL_STYLE` selects the product generator: 0 uses a native multiplier, 1 uses a chain of shift-and-add partial products. Both produce identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation accepted this cycle |
| op_hi | input | 1 | Select upper half of product |
| op_ext | input | 1 | Add stored carry flag as carry-in |
| op_setc | input | 1 | Write carry-out to flag |
| mul_a | input | W | Unsigned multiplicand |
| mul_b | input | W | Unsigned multiplier |
| addend | input | W | Addend word for this half |
| out_valid | output | 1 | Result valid |
| result | output | W | Registered W-bit result |
| carry_flag | output | 1 | Persistent carry flag |

## Verification
The bench builds the unit with W=32 and MUL_STYLE=1. This exercises the 32-row shift-and-add chain against a 64-bit reference product computed natively in the bench, so any dropped or misaligned partial-product row shows up as a miscompare. The all-ones operands and addends drive the low sum to its maximum carry. The back-to-back issue of low and high steps reaches the path where a flag written in one cycle feeds the carry-in of the next.

// File: rtl/madd_split_pkg.sv
package madd_split_pkg;
   typedef struct packed {
      logic hi;
      logic ext;
      logic setc;
   } madd_mod_t;

   localparam int MUL_NATIVE = 0;
   localparam int MUL_SHIFT_ADD = 1;
endpackage

// File: rtl/madd_product.sv
module madd_product #(
   parameter int W = 32,
   parameter int MUL_STYLE = 0
) (
   input  logic [W-1:0]   mul_a,
   input  logic [W-1:0]   mul_b,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;

   generate
      if (MUL_STYLE == madd_split_pkg::MUL_NATIVE) begin : g_native
         assign prod = {{W{1'b0}}, mul_a} * {{W{1'b0}}, mul_b};
      end else begin : g_shift_add
         logic [PW-1:0] acc [0:W];
         logic [PW-1:0] a_wide;
         assign a_wide = {{W{1'b0}}, mul_a};
         assign acc[0] = '0;
         for (genvar i = 0; i < W; i++) begin : g_row
            assign acc[i+1] = acc[i] + (mul_b[i] ? (a_wide << i) : {PW{1'b0}});
         end
         assign prod = acc[W];
      end
   endgenerate
endmodule

// File: rtl/madd_half_sum.sv
module madd_half_sum #(
   parameter int W = 32
) (
   input  logic [2*W-1:0] prod,
   input  logic           sel_hi,
   input  logic [W-1:0]   addend,
   input  logic           cin,
   output logic [W-1:0]   sum,
   output logic           cout
);
   logic [W-1:0] part;
   logic [W:0]   wide;

   assign part = sel_hi ? prod[2*W-1:W] : prod[W-1:0];
   assign wide = {1'b0, part} + {1'b0, addend} + {{W{1'b0}}, cin};
   assign sum  = wide[W-1:0];
   assign cout = wide[W];
endmodule

// File: rtl/madd_flag_reg.sv
module madd_flag_reg (
   input  logic clk,
   input  logic rst,
   input  logic we,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)     q <= 1'b0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/madd_split.sv
module madd_split #(
   parameter int W = 32,
   parameter int MUL_STYLE = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic         op_hi,
   input  logic         op_ext,
   input  logic         op_setc,
   input  logic [W-1:0] mul_a,
   input  logic [W-1:0] mul_b,
   input  logic [W-1:0] addend,
   output logic         out_valid,
   output logic [W-1:0] result,
   output logic         carry_flag
);
   import madd_split_pkg::*;

   generate
      if (W < 2 || W > 64) begin : g_bad_width
         $error("madd_split: W must lie in 2..64");
      end
      if (MUL_STYLE != MUL_NATIVE && MUL_STYLE != MUL_SHIFT_ADD) begin : g_bad_style
         $error("madd_split: unknown MUL_STYLE");
      end
   endgenerate

   madd_mod_t    mods;
   logic [2*W-1:0] prod;
   logic [W-1:0] sum;
   logic         cin;
   logic         cout;
   logic         flag_we;

   assign mods    = '{hi: op_hi, ext: op_ext, setc: op_setc};
   assign cin     = mods.ext & carry_flag;
   assign flag_we = in_valid & mods.setc;

   madd_product #(.W(W), .MUL_STYLE(MUL_STYLE)) u_prod (
      .mul_a (mul_a),
      .mul_b (mul_b),
      .prod  (prod)
   );

   madd_half_sum #(.W(W)) u_sum (
      .prod   (prod),
      .sel_hi (mods.hi),
      .addend (addend),
      .cin    (cin),
      .sum    (sum),
      .cout   (cout)
   );

   madd_flag_reg u_flag (
      .clk (clk),
      .rst (rst),
      .we  (flag_we),
      .d   (cout),
      .q   (carry_flag)
   );

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) result <= sum;
   end
endmodule

// File: rtl/madd_split_chk.sv
module madd_split_chk #(
   parameter int W = 32,
   parameter int MUL_STYLE = 0
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic         op_hi,
   input logic         op_ext,
   input logic         op_setc,
   input logic [W-1:0] mul_a,
   input logic [W-1:0] mul_b,
   input logic [W-1:0] addend,
   input logic         out_valid,
   input logic [W-1:0] result,
   input logic         carry_flag
);
   logic [2*W-1:0] ref_prod;
   logic [W-1:0]   ref_lo;
   logic [W-1:0]   ref_hi;

   assign ref_prod = {{W{1'b0}}, mul_a} * {{W{1'b0}}, mul_b};
   assign ref_lo   = ref_prod[W-1:0] + addend;
   assign ref_hi   = ref_prod[2*W-1:W] + addend;

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);                                   // R1
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);                                 // R1
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));                            // R1
   AST_LOW_PLAIN: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !op_hi && !op_ext) |=> (result == $past(ref_lo)));  // R2
   AST_HIGH_PLAIN: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_hi && !op_ext) |=> (result == $past(ref_hi)));   // R3
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!in_valid || !op_setc) |=> $stable(carry_flag));          // R6
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!carry_flag && !out_valid));                      // R7
endmodule

bind madd_split madd_split_chk #(.W(W), .MUL_STYLE(MUL_STYLE)) u_chk (.*);

// File: tb/tb_madd_split.sv
`timescale 1ns/1ps
module tb_madd_split;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic          op_hi, op_ext, op_setc;
   logic [W-1:0]  mul_a, mul_b, addend;
   logic          out_valid;
   logic [W-1:0]  result;
   logic          carry_flag;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   logic ref_flag = 1'b0;

   always #2 clk = ~clk;

   madd_split #(.W(W), .MUL_STYLE(1)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .op_hi(op_hi), .op_ext(op_ext), .op_setc(op_setc),
      .mul_a(mul_a), .mul_b(mul_b), .addend(addend),
      .out_valid(out_valid), .result(result), .carry_flag(carry_flag)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W:0] model(input logic hi, input logic ext,
                                        input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic [W-1:0] ad, input logic fl);
      logic [63:0] p;
      logic [W-1:0] part;
      p = {32'h0, a} * {32'h0, b};
      part = hi ? p[63:32] : p[31:0];
      return {1'b0, part} + {1'b0, ad} + {{W{1'b0}}, (ext & fl)};
   endfunction

   task automatic issue(input logic hi, input logic ext, input logic setc,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] ad, input string req,
                        output logic [W-1:0] got);
      logic [W:0] s;
      s = model(hi, ext, a, b, ad, ref_flag);
      in_valid = 1'b1; op_hi = hi; op_ext = ext; op_setc = setc;
      mul_a = a; mul_b = b; addend = ad;
      @(negedge clk);
      if (setc) ref_flag = s[W];
      check({req, " R1 valid"}, {63'h0, out_valid}, 64'h1);
      check({req, " result"}, {32'h0, result}, {32'h0, s[W-1:0]});
      check({req, " R5/R6 flag"}, {63'h0, carry_flag}, {63'h0, ref_flag});
      got = result;
      in_valid = 1'b0;
   endtask

   task automatic pair(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [63:0] ad, input string req);
      logic [W-1:0] lo, hi;
      logic [63:0] exp;
      exp = ({32'h0, a} * {32'h0, b}) + ad;
      issue(1'b0, 1'b0, 1'b1, a, b, ad[31:0], {req, " R2 low"}, lo);
      issue(1'b1, 1'b1, 1'b0, a, b, ad[63:32], {req, " R3/R4 high"}, hi);
      check({req, " R8 pair"}, {hi, lo}, exp);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected<=150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] r, held;
      void'($urandom(32'h5eed_1234));
      rst = 1'b1; in_valid = 1'b0; op_hi = 0; op_ext = 0; op_setc = 0;
      mul_a = 0; mul_b = 0; addend = 0;
      repeat (3) @(negedge clk);
      // R7: reset state
      check("R7 reset valid", {63'h0, out_valid}, 64'h0);
      check("R7 reset flag", {63'h0, carry_flag}, 64'h0);
      rst = 1'b0;
      @(negedge clk);

      // R2/R5: all-ones low step sets flag
      issue(1'b0, 1'b0, 1'b1, '1, '1, '1, "R2 ones low setc", r);
      // R6: idle cycle with setc asserted leaves flag and result alone
      held = r;
      op_setc = 1'b1; op_hi = 1'b0; mul_a = 0; mul_b = 0; addend = 0;
      @(negedge clk);
      check("R6 idle flag", {63'h0, carry_flag}, {63'h0, ref_flag});
      check("R1 idle valid", {63'h0, out_valid}, 64'h0);
      check("R1 idle result held", {32'h0, result}, {32'h0, held});
      // R6: accepted op without setc keeps flag
      issue(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, "R6 no-setc op", r);
      // R4: ext on low step uses flag
      issue(1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, "R4 ext low", r);
      // R3: high half of all-ones product
      issue(1'b1, 1'b0, 1'b1, '1, '1, '1, "R3 ones high setc", r);

      // R8: directed pairs
      pair('1, '1, 64'hFFFF_FFFF_FFFF_FFFF, "ones");
      pair(32'h0, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, "zero prod");
      pair(32'h1, 32'h1, 64'h0000_0000_FFFF_FFFF, "carry ripple");
      pair(32'h8000_0000, 32'h2, 64'h0, "top bit");

      // R9: random pairs through shift-add generator
      for (int i = 0; i < 200; i++)
         pair($urandom, $urandom, {$urandom, $urandom}, "rand R9");

      // R2..R6: random modifier mix, back to back
      for (int i = 0; i < 300; i++) begin
         logic [2:0] m;
         m = 3'($urandom);
         issue(m[2], m[1], m[0], $urandom, $urandom,
               (i % 7 == 0) ? '1 : $urandom, "mix R2/R3", r);
      end

      // R7: reset after flag set
      issue(1'b0, 1'b0, 1'b1, '1, '1, '1, "R5 pre-reset", r);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0; ref_flag = 1'b0;
      check("R7 mid reset flag", {63'h0, carry_flag}, 64'h0);
      check("R7 mid reset valid", {63'h0, out_valid}, 64'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule